// File: doc/BRIEF.md
# Cascadable Three-Channel Timer Unit

This block holds three 16-bit timer/counters behind a small register bus. Channels 0 and 1 each own one input pin and one output pin. The input pin acts either as a count clock, where each synchronized rising edge is one count, or as a gate that lets the internal clock count only while the pin is high. The output pin toggles at every terminal count, so a channel can produce a square wave or a single edge. Channel 2 has no pins and counts only the internal clock. Its terminal-count pulse can be chosen as the count source for channel 0 or channel 1, which makes channel 2 a programmable prescaler.

Each channel counts from zero up to its limit register. On the count after the limit it returns to zero and signals terminal count. In continuous mode the channel keeps running. In single-shot mode it clears its own enable bit. A terminal count with interrupts enabled marks that channel pending. One shared request line stays high while any channel is pending. A 2-bit field beside it names the lowest-numbered pending channel, and an acknowledge pulse retires the channel being named.

Top module: `cascade_timer`

## Requirements
- R1: After reset all counts, limits and control registers read 0, `irqReq` is 0 and `tmrOut` is 0.
- R2: With internal clocking, an enabled channel adds one to its count on every clock. A count that equals the limit goes to 0 on the next count, so a continuous channel has a period of limit+1 clocks.
- R3: In single-shot mode (continuous bit 0), the terminal count sets the count to 0 and clears the enable bit, and counting stops.
- R4: With clock select 1, channel 0 or 1 counts each rising edge of its `tmrIn` pin after a two-flop synchronizer.
- R5: With clock select 0 and the gate bit set, channel 0 or 1 counts internal clocks only while its synchronized `tmrIn` is high. It holds its count while the pin is low.
- R6: With clock select 2 or 3, channel 0 or 1 counts one step per terminal count of channel 2.
- R7: Channel 2 ignores its clock-select and gate bits and always counts the internal clock.
- R8: A terminal count on a channel whose interrupt-enable bit is set makes that channel pending. `irqReq` is high while any channel is pending, `irqSrc` gives the lowest-numbered pending channel, and an `irqAck` pulse clears the channel that `irqSrc` names.
- R9: If a channel reaches terminal count in the same cycle that `irqAck` retires it, the channel stays pending.
- R10: A bus write to a count register takes priority over a count tick in the same cycle, and the written value is the new count.
- R11: `tmrOut[n]` toggles at every terminal count of channel n (n = 0, 1).
- R12: Register address = {channel[1:0], register[1:0]}. Register 0 is the count, register 1 is the limit, and register 2 is control. Register 3 and channel 3 read 0. Control bits: 0 enable, 1 continuous, 2 interrupt enable, 4:3 clock select (0 internal, 1 pin edges, 2/3 channel 2), 5 gate. Control reads back as it was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 4 | Register address {channel, register} |
| busWrEn | input | 1 | Write strobe for the addressed register |
| busWrData | input | 16 | Write data |
| busRdData | output | 16 | Combinational read data of the addressed register |
| tmrIn | input | 2 | Clock or gate pins of channels 0 and 1 |
| tmrOut | output | 2 | Toggle outputs of channels 0 and 1 |
| irqAck | input | 1 | Retires the channel named by `irqSrc` |
| irqReq | output | 1 | Shared interrupt request |
| irqSrc | output | 2 | Lowest-numbered pending channel |

## Verification
Two pairs of events can land in the same cycle. In the first, a terminal count and an interrupt acknowledge hit the same channel. The bench provokes this by setting a limit of 0, so the channel reaches terminal count on every clock, and then holding `irqAck` high for several cycles. `irqReq` must never drop. In the second, a bus write to a count register meets a running tick. The count seen right after the write must equal the written value exactly, with no extra step added, and counting then resumes from that value.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;
  localparam int NUM_CH = 3;
  localparam int PIN_CH = 2;
  localparam int ADDR_W = 4;
  localparam int CTRL_W = 6;

  localparam logic [1:0] REG_COUNT = 2'd0;
  localparam logic [1:0] REG_LIMIT = 2'd1;
  localparam logic [1:0] REG_CTRL  = 2'd2;

  localparam int CB_EN   = 0;
  localparam int CB_CONT = 1;
  localparam int CB_IRQ  = 2;
  localparam int CB_CSEL = 3;
  localparam int CB_GATE = 5;

  localparam logic [1:0] CSEL_INT = 2'd0;
  localparam logic [1:0] CSEL_PIN = 2'd1;

  typedef struct packed {
    logic tick;
    logic ldCount;
    logic ldLimit;
  } ch_strobe_t;
endpackage

// File: rtl/ctmr_sync.sv
module ctmr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic level,
  output logic rise
);
  logic [STAGES:0] shreg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shreg <= '0;
    else       shreg <= {shreg[STAGES-1:0], din};
  end

  assign level = shreg[STAGES-1];
  assign rise  = shreg[STAGES-1] & ~shreg[STAGES];
endmodule

// File: rtl/ctmr_ctrl.sv
module ctmr_ctrl
  import ctmr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [ADDR_W-1:0]              busAddr,
  input  logic                           busWrEn,
  input  logic [CTRL_W-1:0]              wrCtrlData,
  input  logic [PIN_CH-1:0]              tmrIn,
  input  logic [NUM_CH-1:0]              atLimit,
  input  logic                           irqAck,
  output ch_strobe_t [NUM_CH-1:0]        strb,
  output logic [NUM_CH-1:0][CTRL_W-1:0]  ctrlVal,
  output logic [PIN_CH-1:0]              tmrOut,
  output logic                           irqReq,
  output logic [1:0]                     irqSrc
);
  logic [NUM_CH-1:0][CTRL_W-1:0] ctrlReg;
  logic [NUM_CH-1:0] wrCtrl, ldCnt, ldLim, tick, tc, pend, setPend;
  logic [PIN_CH-1:0] pinLvl, pinRise, pinTick, outReg;
  logic ch2Tick, prescTc;
  logic [1:0] chSel, regSel;

  assign chSel  = busAddr[3:2];
  assign regSel = busAddr[1:0];

  always_comb begin
    for (int i = 0; i < NUM_CH; i++) begin
      wrCtrl[i] = busWrEn && (chSel == 2'(i)) && (regSel == REG_CTRL);
      ldCnt[i]  = busWrEn && (chSel == 2'(i)) && (regSel == REG_COUNT);
      ldLim[i]  = busWrEn && (chSel == 2'(i)) && (regSel == REG_LIMIT);
    end
  end

  for (genvar p = 0; p < PIN_CH; p++) begin : g_pin
    ctmr_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rstN (rstN),
      .din  (tmrIn[p]),
      .level(pinLvl[p]),
      .rise (pinRise[p])
    );
  end

  // channel 2: internal clock only, its own select and gate bits unused
  assign ch2Tick = ctrlReg[2][CB_EN];
  assign prescTc = ch2Tick & atLimit[2] & ~ldCnt[2];

  always_comb begin
    for (int p = 0; p < PIN_CH; p++) begin
      case (ctrlReg[p][CB_CSEL +: 2])
        CSEL_INT: pinTick[p] = ctrlReg[p][CB_EN] & (~ctrlReg[p][CB_GATE] | pinLvl[p]);
        CSEL_PIN: pinTick[p] = ctrlReg[p][CB_EN] & pinRise[p];
        default:  pinTick[p] = ctrlReg[p][CB_EN] & prescTc;
      endcase
    end
  end

  assign tick    = {ch2Tick, pinTick};
  assign tc      = tick & atLimit & ~ldCnt;

  always_comb begin
    for (int i = 0; i < NUM_CH; i++) setPend[i] = tc[i] & ctrlReg[i][CB_IRQ];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
      pend    <= '0;
      outReg  <= '0;
    end else begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (wrCtrl[i])                         ctrlReg[i] <= wrCtrlData;
        else if (tc[i] && !ctrlReg[i][CB_CONT]) ctrlReg[i][CB_EN] <= 1'b0;
        if (setPend[i])                                  pend[i] <= 1'b1;
        else if (irqAck && irqReq && irqSrc == 2'(i))    pend[i] <= 1'b0;
      end
      for (int p = 0; p < PIN_CH; p++) begin
        if (tc[p]) outReg[p] <= ~outReg[p];
      end
    end
  end

  always_comb begin
    irqSrc = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (pend[i]) irqSrc = 2'(i);
    end
  end

  assign irqReq  = |pend;
  assign tmrOut  = outReg;
  assign ctrlVal = ctrlReg;

  always_comb begin
    for (int i = 0; i < NUM_CH; i++) begin
      strb[i].tick    = tick[i];
      strb[i].ldCount = ldCnt[i];
      strb[i].ldLimit = ldLim[i];
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    // R3
    oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
      (tc[i] && !ctrlReg[i][CB_CONT] && !wrCtrl[i]) |=> !ctrlReg[i][CB_EN]);
    // R9
    irq_set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
      (tc[i] && ctrlReg[i][CB_IRQ]) |=> (irqReq && pend[i]));
    // R8
    irq_retire_chk: assert property (@(posedge clk) disable iff (!rstN)
      (irqAck && irqReq && irqSrc == 2'(i) && !setPend[i]) |=> !pend[i]);
  end
endmodule

// File: rtl/ctmr_datapath.sv
module ctmr_datapath
  import ctmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  ch_strobe_t [NUM_CH-1:0]        strb,
  input  logic [CNT_W-1:0]               wrData,
  input  logic [ADDR_W-1:0]              busAddr,
  input  logic [NUM_CH-1:0][CTRL_W-1:0]  ctrlVal,
  output logic [NUM_CH-1:0]              atLimit,
  output logic [CNT_W-1:0]               rdData
);
  logic [NUM_CH-1:0][CNT_W-1:0] cnt, lim;
  logic [1:0] chSel, regSel;

  assign chSel  = busAddr[3:2];
  assign regSel = busAddr[1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
      lim <= '0;
    end else begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (strb[i].ldCount)   cnt[i] <= wrData;
        else if (strb[i].tick) cnt[i] <= atLimit[i] ? '0 : cnt[i] + 1'b1;
        if (strb[i].ldLimit)   lim[i] <= wrData;
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_CH; i++) atLimit[i] = (cnt[i] == lim[i]);
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (chSel == 2'(i)) begin
        case (regSel)
          REG_COUNT: rdData = cnt[i];
          REG_LIMIT: rdData = lim[i];
          REG_CTRL:  rdData[CTRL_W-1:0] = ctrlVal[i];
          default:   rdData = '0;
        endcase
      end
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    // R2
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
      (strb[i].tick && atLimit[i] && !strb[i].ldCount) |=> (cnt[i] == '0));
    // R10
    load_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
      strb[i].ldCount |=> (cnt[i] == $past(wrData)));
  end
endmodule

// File: rtl/cascade_timer.sv
module cascade_timer
  import ctmr_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [CNT_W-1:0]  busWrData,
  output logic [CNT_W-1:0]  busRdData,
  input  logic [PIN_CH-1:0] tmrIn,
  output logic [PIN_CH-1:0] tmrOut,
  input  logic              irqAck,
  output logic              irqReq,
  output logic [1:0]        irqSrc
);
  ch_strobe_t [NUM_CH-1:0]       strb;
  logic [NUM_CH-1:0][CTRL_W-1:0] ctrlVal;
  logic [NUM_CH-1:0]             atLimit;

  ctmr_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busAddr   (busAddr),
    .busWrEn   (busWrEn),
    .wrCtrlData(busWrData[CTRL_W-1:0]),
    .tmrIn     (tmrIn),
    .atLimit   (atLimit),
    .irqAck    (irqAck),
    .strb      (strb),
    .ctrlVal   (ctrlVal),
    .tmrOut    (tmrOut),
    .irqReq    (irqReq),
    .irqSrc    (irqSrc)
  );

  ctmr_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .wrData (busWrData),
    .busAddr(busAddr),
    .ctrlVal(ctrlVal),
    .atLimit(atLimit),
    .rdData (busRdData)
  );
endmodule

// File: tb/cascade_timer_test.sv
`timescale 1ns/1ps
module cascade_timer_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [15:0] busWrData = '0;
  logic [15:0] busRdData;
  logic [1:0]  tmrIn = '0;
  logic [1:0]  tmrOut;
  logic        irqAck = 1'b0;
  logic        irqReq;
  logic [1:0]  irqSrc;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  cascade_timer uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .tmrIn(tmrIn),
    .tmrOut(tmrOut), .irqAck(irqAck), .irqReq(irqReq), .irqSrc(irqSrc)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] ch, input logic [1:0] rg, input logic [15:0] d);
    @(negedge clk);
    busAddr = {ch, rg}; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] ch, input logic [1:0] rg, output logic [15:0] v);
    busAddr = {ch, rg};
    #0.5;
    v = busRdData;
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; tmrIn = '0; irqAck = 1'b0; busWrEn = 1'b0;
    waitCyc(2);
    rstN = 1'b1;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    doReset();
    for (int c = 0; c < 3; c++) begin
      for (int r = 0; r < 3; r++) begin
        rd(c[1:0], r[1:0], v);
        check("R1 register after reset", v, 16'h0);
      end
    end
    check("R1 irqReq", {15'd0, irqReq}, 16'h0);
    check("R1 tmrOut", {14'd0, tmrOut}, 16'h0);
  endtask

  task automatic t_wrap();
    logic [15:0] v;
    doReset();
    wr(2'd2, 2'd1, 16'd4);
    wr(2'd2, 2'd2, 16'h0003);
    waitCyc(7);
    rd(2'd2, 2'd0, v);
    check("R2 count wraps after limit", v, 16'd2);
    waitCyc(3);
    rd(2'd2, 2'd0, v);
    check("R2 count period limit+1", v, 16'd0);
  endtask

  task automatic t_ch2Ignores();
    logic [15:0] v;
    doReset();
    wr(2'd2, 2'd1, 16'hFFFF);
    wr(2'd2, 2'd2, 16'h002B);
    waitCyc(10);
    rd(2'd2, 2'd0, v);
    check("R7 ch2 counts internal clock despite select and gate", v, 16'd10);
    rd(2'd2, 2'd2, v);
    check("R12 control readback", v, 16'h002B);
    rd(2'd2, 2'd3, v);
    check("R12 register 3 reads zero", v, 16'h0);
    rd(2'd3, 2'd0, v);
    check("R12 channel 3 reads zero", v, 16'h0);
  endtask

  task automatic t_oneShot();
    logic [15:0] v;
    doReset();
    wr(2'd1, 2'd1, 16'd3);
    wr(2'd1, 2'd2, 16'h0001);
    waitCyc(2);
    rd(2'd1, 2'd0, v);
    check("R3 one-shot counting", v, 16'd2);
    waitCyc(8);
    rd(2'd1, 2'd0, v);
    check("R3 one-shot count zero and stopped", v, 16'd0);
    rd(2'd1, 2'd2, v);
    check("R3 enable cleared", v, 16'h0000);
    check("R11 out1 toggled once", {14'd0, tmrOut}, 16'h2);
  endtask

  task automatic t_extClock();
    logic [15:0] v;
    doReset();
    wr(2'd1, 2'd1, 16'hFFFF);
    wr(2'd1, 2'd2, 16'h000B);
    for (int k = 0; k < 5; k++) begin
      tmrIn[1] = 1'b1; waitCyc(3);
      tmrIn[1] = 1'b0; waitCyc(3);
    end
    waitCyc(6);
    rd(2'd1, 2'd0, v);
    check("R4 external rising edges counted", v, 16'd5);
  endtask

  task automatic t_gate();
    logic [15:0] v, a;
    doReset();
    wr(2'd0, 2'd1, 16'hFFFF);
    wr(2'd0, 2'd2, 16'h0023);
    waitCyc(10);
    rd(2'd0, 2'd0, v);
    check("R5 gate low holds count", v, 16'd0);
    tmrIn[0] = 1'b1;
    waitCyc(10);
    rd(2'd0, 2'd0, v);
    check("R5 gate high counts after sync", v, 16'd8);
    tmrIn[0] = 1'b0;
    waitCyc(10);
    rd(2'd0, 2'd0, a);
    check("R5 count after gate drop", a, 16'd10);
    waitCyc(5);
    rd(2'd0, 2'd0, v);
    check("R5 gate low keeps count stable", v, a);
  endtask

  task automatic t_prescale();
    logic [15:0] v;
    doReset();
    wr(2'd0, 2'd1, 16'hFFFF);
    wr(2'd0, 2'd2, 16'h0013);
    wr(2'd2, 2'd1, 16'd3);
    wr(2'd2, 2'd2, 16'h0003);
    waitCyc(20);
    rd(2'd0, 2'd0, v);
    check("R6 ch0 counts ch2 terminal counts", v, 16'd5);
    rd(2'd2, 2'd0, v);
    check("R2 ch2 count with limit 3", v, 16'd0);
  endtask

  task automatic t_irqPriority();
    doReset();
    wr(2'd0, 2'd2, 16'h0005);
    wr(2'd1, 2'd2, 16'h0005);
    waitCyc(3);
    check("R8 request raised", {15'd0, irqReq}, 16'h1);
    check("R8 lowest pending source", {14'd0, irqSrc}, 16'h0);
    check("R11 both outputs toggled", {14'd0, tmrOut}, 16'h3);
    irqAck = 1'b1; waitCyc(1); irqAck = 1'b0;
    check("R8 after first ack request", {15'd0, irqReq}, 16'h1);
    check("R8 after first ack source", {14'd0, irqSrc}, 16'h1);
    irqAck = 1'b1; waitCyc(1); irqAck = 1'b0;
    check("R8 after second ack", {15'd0, irqReq}, 16'h0);
  endtask

  task automatic t_ackCollide();
    doReset();
    wr(2'd0, 2'd2, 16'h0007);
    waitCyc(3);
    irqAck = 1'b1;
    for (int k = 0; k < 5; k++) begin
      waitCyc(1);
      check("R9 terminal count beats ack", {15'd0, irqReq}, 16'h1);
    end
    irqAck = 1'b0;
    wr(2'd0, 2'd2, 16'h0000);
    waitCyc(2);
    irqAck = 1'b1; waitCyc(1); irqAck = 1'b0;
    check("R8 ack retires once stopped", {15'd0, irqReq}, 16'h0);
  endtask

  task automatic t_loadWins();
    logic [15:0] v;
    doReset();
    wr(2'd2, 2'd1, 16'hFFFF);
    wr(2'd2, 2'd2, 16'h0003);
    waitCyc(5);
    wr(2'd2, 2'd0, 16'd100);
    rd(2'd2, 2'd0, v);
    check("R10 write wins over tick", v, 16'd100);
    waitCyc(4);
    rd(2'd2, 2'd0, v);
    check("R10 counting resumes from written value", v, 16'd104);
  endtask

  initial begin
    t_reset();
    t_wrap();
    t_ch2Ignores();
    t_oneShot();
    t_extClock();
    t_gate();
    t_prescale();
    t_irqPriority();
    t_ackCollide();
    t_loadWins();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule